// File: doc/BRIEF.md
# SPI Register Burst Access Slave

This block lets an external SPI host read and write a word-addressed register space inside the chip. Every chip-select frame begins with a 32-bit command word that selects the direction, gives a word count for reads and gives a starting word address. After the command word, the host clocks 32-bit data words. The block turns each data word into one access on a simple synchronous register bus, and the address steps by one per word.

The SPI pins are brought into the system clock domain through a synchroniser chain, and their edges are found by oversampling. The SPI link runs in mode 0: the host drives MOSI and the block drives MISO on falling SCK edges, both sample on rising edges, and everything is sent most significant bit first. For reads, the first register read is issued as soon as the command word is complete. From then on, the next word is always fetched one word ahead, so a word is ready in time for the first falling SCK edge of its slot. A frame carries at most 64 data words. The host must split longer transfers into several frames, each with its own command word.

Top module: `spi_reg_access`

## Requirements
- R1: SPI mode 0, MSB first. The first 32 bits of a frame form the command word, and its bit 31 selects the direction: 1 means write and 0 means read.
- R2: In a write frame, every complete 32-bit data word produces exactly one single-cycle `reg_wr` that carries that word. The first write goes to the command word's address field (bits 24..4), and each later write goes to the next address.
- R3: A write frame issues no more than 64 register writes. Any data words after the 64th are dropped.
- R4: If chip select rises before a word's 32nd bit, the partial word is dropped. No register write is issued for it, and the next frame starts again at bit 0.
- R5: In a read frame, the first `reg_rd` is issued right after the command word. Its data appears on MISO, MSB first, starting at the falling SCK edge that follows the command's last bit.
- R6: A read frame issues exactly as many `reg_rd` strobes as the count field (bits 30..25) gives, with a count of 0 meaning 64. The addresses start at the address field and increase by one, wrapping modulo 2^21.
- R7: Once the counted words have been sent, MISO carries zeros for the rest of the frame, and no further reads are issued.
- R8: Data that the host shifts in on MOSI during a read frame causes no register write.
- R9: While chip select is high, MISO is 0 and no register access is issued. A new frame always starts with a fresh command word.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle, and each access is a one-cycle strobe.
- R11: After reset, `reg_wr`, `reg_rd` and `spi_miso` are 0.
- R12: Command bits 3..0 are ignored. They do not change the address or any other behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from host (idles low) |
| spi_cs_n | input | 1 | Active-low chip select from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | ADDR_W (21) | Register word address |
| reg_wdata | output | WORD_W (32) | Register write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | WORD_W (32) | Read data, valid the cycle after `reg_rd` |

## Verification
The bench builds the block with its default parameters: a 21-bit address, a 6-bit count field, a 64-word frame limit and two synchroniser stages. Because the frame limit equals 2^6, the variant in which a count of zero means a full 64-word read is the one built. Sending frames of 66 words and of 64 reads is cheap enough to cover both the write cap and that count encoding. With the 21-bit address, a read that starts two words below the top of the space also exercises the address wrap.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;
   // Frame phase: command word, then write data or read data
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2
   } phase_e;
endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   logic [W-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/spi_ra_shifter.sv
module spi_ra_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_act,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [WORD_W-1:0] tx_word,
   output logic              word_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              miso
);
   localparam int BC_W = $clog2(WORD_W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

   logic              sck_d;
   logic [BC_W-1:0]   bit_cnt;
   logic [WORD_W-1:0] rx_sr;
   logic [WORD_W-1:0] tx_sr;
   logic              miso_q;
   logic              rise;
   logic              fall;

   assign rise = cs_act &  sck_s & ~sck_d;
   assign fall = cs_act & ~sck_s &  sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         miso_q    <= 1'b0;
         word_done <= 1'b0;
         rx_word   <= '0;
      end else begin
         sck_d     <= sck_s;
         word_done <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_BIT) begin
                  word_done <= 1'b1;
                  rx_word   <= {rx_sr[WORD_W-2:0], mosi_s};
               end
            end
            if (tx_load) begin
               tx_sr <= tx_word;
            end else if (fall) begin
               miso_q <= tx_sr[WORD_W-1];
               tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = cs_act & miso_q;

   // R5: a word load never coincides with a shifting edge
   assert_load_apart_from_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> !fall);
   // R4: dropping chip select restarts the bit count
   assert_idle_clears_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_ra_burst.sv
module spi_ra_burst
   import spi_ra_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 6,
   parameter int MAX_WORDS = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              word_done,
   input  logic [WORD_W-1:0] rx_word,
   output logic              tx_load,
   output logic [WORD_W-1:0] tx_word,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [WORD_W-1:0] reg_rdata
);
   localparam int DIR_BIT  = WORD_W - 1;
   localparam int CNT_LSB  = DIR_BIT - CNT_W;
   localparam int ADDR_LSB = CNT_LSB - ADDR_W;
   localparam int LEN_W    = $clog2(MAX_WORDS + 1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_WORDS);

   phase_e            phase;
   logic [ADDR_W-1:0] ptr;
   logic [LEN_W-1:0]  left;
   logic [LEN_W-1:0]  wcnt;
   logic [WORD_W-1:0] nxt;
   logic              nxt_vld;
   logic              dest_tx;
   logic              rvalid;

   logic              cmd_wr;
   logic [CNT_W-1:0]  cmd_cnt;
   logic [ADDR_W-1:0] cmd_addr;
   logic [LEN_W-1:0]  cmd_len;

   assign cmd_wr   = rx_word[DIR_BIT];
   assign cmd_cnt  = rx_word[CNT_LSB +: CNT_W];
   assign cmd_addr = rx_word[ADDR_LSB +: ADDR_W];

   generate
      if (MAX_WORDS == (1 << CNT_W)) begin : g_zero_is_full
         assign cmd_len = (cmd_cnt == '0) ? LEN_MAX : LEN_W'(cmd_cnt);
      end else begin : g_zero_is_none
         assign cmd_len = LEN_W'(cmd_cnt);
      end
   endgenerate

   // First word goes straight to the shifter; later words come from the prefetch slot
   assign tx_load = (rvalid & dest_tx) | (word_done & (phase == PH_RD));
   assign tx_word = (rvalid & dest_tx) ? reg_rdata : (nxt_vld ? nxt : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         ptr       <= '0;
         left      <= '0;
         wcnt      <= '0;
         nxt       <= '0;
         nxt_vld   <= 1'b0;
         dest_tx   <= 1'b0;
         rvalid    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         rvalid <= reg_rd;
         if (!cs_act) begin
            phase   <= PH_CMD;
            left    <= '0;
            wcnt    <= '0;
            nxt_vld <= 1'b0;
            dest_tx <= 1'b0;
         end else begin
            if (word_done) begin
               unique case (phase)
                  PH_CMD: begin
                     ptr  <= cmd_addr;
                     wcnt <= '0;
                     if (cmd_wr) begin
                        phase <= PH_WR;
                     end else begin
                        phase <= PH_RD;
                        if (cmd_len != '0) begin
                           reg_rd   <= 1'b1;
                           reg_addr <= cmd_addr;
                           ptr      <= cmd_addr + 1'b1;
                           left     <= cmd_len - 1'b1;
                           dest_tx  <= 1'b1;
                        end else begin
                           left <= '0;
                        end
                     end
                  end
                  PH_WR: begin
                     if (wcnt < LEN_MAX) begin
                        reg_wr    <= 1'b1;
                        reg_addr  <= ptr;
                        reg_wdata <= rx_word;
                        ptr       <= ptr + 1'b1;
                        wcnt      <= wcnt + 1'b1;
                     end
                  end
                  PH_RD: begin
                     nxt_vld <= 1'b0;
                     if (left != '0) begin
                        reg_rd   <= 1'b1;
                        reg_addr <= ptr;
                        ptr      <= ptr + 1'b1;
                        left     <= left - 1'b1;
                        dest_tx  <= 1'b0;
                     end
                  end
                  default: phase <= PH_CMD;
               endcase
            end
            if (rvalid) begin
               if (dest_tx) begin
                  dest_tx <= 1'b0;
                  if (left != '0) begin
                     reg_rd   <= 1'b1;
                     reg_addr <= ptr;
                     ptr      <= ptr + 1'b1;
                     left     <= left - 1'b1;
                  end
               end else begin
                  nxt     <= reg_rdata;
                  nxt_vld <= 1'b1;
               end
            end
         end
      end
   end

   assert_no_wr_rd_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
   assert_wr_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   assert_rd_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
   assert_write_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= LEN_MAX);
   assert_access_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) |-> $past(cs_act));
   assert_no_write_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RD) |-> !reg_wr);
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access #(
   parameter int ADDR_W      = 21,
   parameter int WORD_W      = 32,
   parameter int CNT_W       = 6,
   parameter int MAX_WORDS   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [WORD_W-1:0] reg_rdata
);
   generate
      if (WORD_W < 1 + CNT_W + ADDR_W) begin : g_bad_fields
         $error("command fields do not fit in one word");
      end
      if ((WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("WORD_W must be a power of two");
      end
      if (MAX_WORDS > (1 << CNT_W) || MAX_WORDS < 1) begin : g_bad_max
         $error("MAX_WORDS must lie in 1 .. 2**CNT_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       sck_s, cs_n_s, mosi_s, cs_act;
   logic       word_done, tx_load;
   logic [WORD_W-1:0] rx_word, tx_word;

   spi_ra_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_sck, spi_cs_n, spi_mosi}),
      .q_out (pins_s)
   );
   assign sck_s  = pins_s[2];
   assign cs_n_s = pins_s[1];
   assign mosi_s = pins_s[0];
   assign cs_act = ~cs_n_s;

   spi_ra_shifter #(.WORD_W(WORD_W)) shift_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_act    (cs_act),
      .mosi_s    (mosi_s),
      .tx_load   (tx_load),
      .tx_word   (tx_word),
      .word_done (word_done),
      .rx_word   (rx_word),
      .miso      (spi_miso)
   );

   spi_ra_burst #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)
   ) burst_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .word_done (word_done),
      .rx_word   (rx_word),
      .tx_load   (tx_load),
      .tx_word   (tx_word),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_rdata (reg_rdata)
   );

   // R11: strobes stay low through reset release
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |-> (!reg_wr && !reg_rd));
endmodule

// File: tb/spi_reg_access_tb.sv
module spi_reg_access_tb_top;
   localparam int HALF = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso;
   logic [20:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic reg_wr, reg_rd;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct { bit wr; logic [20:0] addr; logic [31:0] data; } ev_t;
   ev_t exp_q[$];

   logic [31:0] tx_words [80];
   logic [31:0] rx_words [80];

   always #2 clk = ~clk;

   spi_reg_access dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   function automatic logic [31:0] rmodel(input logic [20:0] a);
      return {a[10:0], a} ^ 32'hC3A5_0F96;
   endfunction

   always @(posedge clk) if (reg_rd) reg_rdata <= rmodel(reg_addr);

   function automatic logic [31:0] mk_cmd(input bit wr, input logic [5:0] cnt,
                                          input logic [20:0] a, input logic [3:0] lo);
      return {wr, cnt, a, lo};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected access per observed strobe (R2, R6, R10)
   always @(negedge clk) begin
      if (rst_n && (reg_wr || reg_rd)) begin
         ev_t e;
         if (reg_wr && reg_rd) check(1'b0, "R10 overlap", 32'd1, 32'd0);
         if (exp_q.size() == 0) begin
            check(1'b0, "R10/R8 unexpected access", {10'd0, reg_wr, reg_addr}, 32'd0);
         end else begin
            e = exp_q.pop_front();
            check(e.wr == reg_wr, "R2/R6 access kind", {31'd0, reg_wr}, {31'd0, e.wr});
            check(e.addr == reg_addr, "R2/R6 address", {11'd0, reg_addr}, {11'd0, e.addr});
            if (e.wr) check(e.data == reg_wdata, "R2 write data", reg_wdata, e.data);
         end
      end
   end

   task automatic spi_bit(input logic b, output logic r);
      spi_mosi = b;
      #(HALF);
      r = spi_miso;
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
   endtask

   task automatic run_frame(input logic [31:0] cmd, input int nw, input int part);
      logic r;
      logic [31:0] acc;
      spi_cs_n = 1'b0;
      #(HALF);
      for (int b = 31; b >= 0; b--) spi_bit(cmd[b], r);
      for (int w = 0; w < nw; w++) begin
         acc = '0;
         for (int b = 31; b >= 0; b--) begin
            spi_bit(tx_words[w][b], r);
            acc = {acc[30:0], r};
         end
         rx_words[w] = acc;
      end
      for (int b = 0; b < part; b++) spi_bit(tx_words[nw][31-b], r);
      #(HALF);
      spi_cs_n = 1'b1;
      #(4*HALF);
   endtask

   task automatic push_writes(input logic [20:0] a, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back('{1'b1, a + 21'(i), tx_words[i]});
   endtask

   task automatic push_reads(input logic [20:0] a, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, a + 21'(i), 32'd0});
   endtask

   task automatic check_drained(input string req);
      check(exp_q.size() == 0, req, exp_q.size(), 32'd0);
      exp_q.delete();
   endtask

   task automatic check_reads(input logic [20:0] a, input int cnt, input int nw, input string req);
      for (int i = 0; i < nw; i++) begin
         if (i < cnt) check(rx_words[i] == rmodel(a + 21'(i)), req, rx_words[i], rmodel(a + 21'(i)));
         else         check(rx_words[i] == 32'd0, "R7 trailing zero", rx_words[i], 32'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 80; i++) tx_words[i] = 32'hA000_0000 + 32'h0101_0007 * i;
      #1;
      #20;
      check(!reg_wr && !reg_rd, "R11 strobes in reset", {30'd0, reg_wr, reg_rd}, 32'd0);
      check(spi_miso == 1'b0, "R11 miso in reset", {31'd0, spi_miso}, 32'd0);
      rst_n = 1'b1;
      #(4*HALF);

      // R1 R2 R12: three-word write, low command bits set
      push_writes(21'h00123, 3);
      run_frame(mk_cmd(1'b1, 6'd5, 21'h00123, 4'hA), 3, 0);
      check_drained("R2 write count");

      // R5 R6 R8: four reads that wrap at the top of the space, MOSI busy
      for (int i = 0; i < 4; i++) tx_words[i] = 32'hFFFF_FFFF;
      push_reads(21'h1FFFFE, 4);
      run_frame(mk_cmd(1'b0, 6'd4, 21'h1FFFFE, 4'h0), 4, 0);
      check_drained("R6 read count");
      check_reads(21'h1FFFFE, 4, 4, "R5 read data");
      for (int i = 0; i < 80; i++) tx_words[i] = 32'hA000_0000 + 32'h0101_0007 * i;

      // R9: idle miso after frame
      check(spi_miso == 1'b0, "R9 idle miso", {31'd0, spi_miso}, 32'd0);

      // R7: count 2, four words clocked
      push_reads(21'h00040, 2);
      run_frame(mk_cmd(1'b0, 6'd2, 21'h00040, 4'h0), 4, 0);
      check_drained("R7 no extra reads");
      check_reads(21'h00040, 2, 4, "R7 counted data");

      // R3: 66 words, only 64 writes
      push_writes(21'h01000, 64);
      run_frame(mk_cmd(1'b1, 6'd0, 21'h01000, 4'h0), 66, 0);
      check_drained("R3 write cap");

      // R6: count 0 means 64 reads
      push_reads(21'h02200, 64);
      run_frame(mk_cmd(1'b0, 6'd0, 21'h02200, 4'h0), 64, 0);
      check_drained("R6 zero count is 64");
      check_reads(21'h02200, 64, 64, "R6 full read data");

      // R4: two words plus 17 stray bits
      push_writes(21'h00777, 2);
      run_frame(mk_cmd(1'b1, 6'd0, 21'h00777, 4'h0), 2, 17);
      check_drained("R4 partial dropped");

      // R4 R9: next frame starts cleanly with a new command word
      push_reads(21'h00010, 1);
      run_frame(mk_cmd(1'b0, 6'd1, 21'h00010, 4'h0), 1, 0);
      check_drained("R9 fresh command");
      check_reads(21'h00010, 1, 1, "R9 read after partial");
      check(spi_miso == 1'b0, "R9 idle miso end", {31'd0, spi_miso}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(190000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule